// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block turns a pixel-clock enable into the horizontal sync, vertical sync and display-active signals that a raster monitor needs. The length of every phase of a line and of a frame (sync pulse, back porch, visible region, front porch) comes from run-time inputs, and the level at which each sync pulse is asserted is chosen by its own polarity bit. The horizontal axis is counted in units of eight pixels. Each horizontal length input therefore gives a number of eight-pixel units, which keeps the horizontal counter narrow.

Besides the three raster signals, the block brings out separate horizontal-active and vertical-active flags. It also gives a one-cycle frame-done pulse at the end of the last visible line. A framebuffer fetcher uses that pulse to switch to a newly queued buffer during vertical blanking. The timing inputs are captured only while reset is held or in the cycle a start strobe is applied, so software can stage a new mode and then apply it atomically.

Top module: `vgaTimingGen`

## Requirements
- R1: While rstN is low, hSyncOut equals hPolLow, vSyncOut equals vPolLow, and hActOut, vActOut, dispActive and frameDone are all 0.
- R2: One horizontal unit lasts eight cycles in which pixEn is high. All horizontal length inputs count such units.
- R3: Every line starts with hSyncLen units of sync, then hBackLen units of back porch, then hActLen units with hActOut high, then hFrontLen units of front porch. The line period is the sum of the four.
- R4: Every frame starts with vSyncLen lines of vertical sync, then vBackLen lines of back porch, then vActLen lines with vActOut high, then vFrontLen lines of front porch. vSyncOut changes only where a line begins.
- R5: A polarity input of 0 makes its sync output high while asserted. A polarity input of 1 makes it low while asserted.
- R6: dispActive is high exactly when hActOut and vActOut are both high. All six outputs come from one register stage and are mutually aligned.
- R7: frameDone is high for a single cycle once per frame. That cycle is the one in which the last pixel of the last unit of the last visible line is presented.
- R8: A change on any timing or polarity input while rstN is high and start is low has no effect on the outputs.
- R9: While pixEn is low the raster position holds, so gating pixEn on every other cycle doubles every period measured in clock cycles.
- R10: A start pulse captures the inputs and restarts the raster at the first pixel of the first sync line. In the cycle after start the outputs show the inactive levels, and in the cycle after that they show pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; also captures the timing inputs |
| pixEn | input | 1 | Pixel-clock enable |
| start | input | 1 | Capture timing inputs and restart the raster |
| hSyncLen | input | H_W | Horizontal sync length in 8-pixel units |
| hBackLen | input | H_W | Horizontal back porch in 8-pixel units |
| hActLen | input | H_W | Horizontal visible length in 8-pixel units |
| hFrontLen | input | H_W | Horizontal front porch in 8-pixel units |
| vSyncLen | input | V_W | Vertical sync length in lines |
| vBackLen | input | V_W | Vertical back porch in lines |
| vActLen | input | V_W | Vertical visible length in lines |
| vFrontLen | input | V_W | Vertical front porch in lines |
| hPolLow | input | 1 | 1 makes hSyncOut active low |
| vPolLow | input | 1 | 1 makes vSyncOut active low |
| hSyncOut | output | 1 | Horizontal sync |
| vSyncOut | output | 1 | Vertical sync |
| hActOut | output | 1 | Horizontal visible region flag |
| vActOut | output | 1 | Vertical visible region flag |
| dispActive | output | 1 | Display-active window |
| frameDone | output | 1 | One-cycle pulse at the end of the visible region |

## Verification
On every cycle the assertions check four things: the unit tick never fires in two cycles in a row, the horizontal position stays inside the programmed line, vertical sync changes only at line starts outside restarts, and the active window and frame pulse stay consistent. Only the bench scenarios can show the exact lengths and order of the phases under two polarity settings, the frame pulse position, the stall under a gated enable, and the fact that inputs changed without a start are ignored. These scenarios compare every output on every cycle against a position model computed from the requirements.

// File: rtl/vgaTimingPkg.sv
package vgaTimingPkg;
  // Strobes from the control block to the counting datapath
  typedef struct packed {
    logic restart;   // reset or start: reload counters, force inactive outputs
    logic unitTick;  // one 8-pixel unit has elapsed
  } vgaStrobe_t;
endpackage

// File: rtl/vgaTimingCtrl.sv
module vgaTimingCtrl
  import vgaTimingPkg::*;
#(
  parameter int H_W = 8,
  parameter int V_W = 10,
  parameter int PIX_PER_UNIT = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pixEn,
  input  logic           start,
  input  logic [H_W-1:0] hSyncIn,
  input  logic [H_W-1:0] hBackIn,
  input  logic [H_W-1:0] hActIn,
  input  logic [H_W-1:0] hFrontIn,
  input  logic [V_W-1:0] vSyncIn,
  input  logic [V_W-1:0] vBackIn,
  input  logic [V_W-1:0] vActIn,
  input  logic [V_W-1:0] vFrontIn,
  input  logic           hPolIn,
  input  logic           vPolIn,
  output logic [H_W-1:0] hSyncCfg,
  output logic [H_W-1:0] hBackCfg,
  output logic [H_W-1:0] hActCfg,
  output logic [H_W-1:0] hFrontCfg,
  output logic [V_W-1:0] vSyncCfg,
  output logic [V_W-1:0] vBackCfg,
  output logic [V_W-1:0] vActCfg,
  output logic [V_W-1:0] vFrontCfg,
  output logic           hPolCfg,
  output logic           vPolCfg,
  output vgaStrobe_t     strb
);
  localparam int PRE_W = (PIX_PER_UNIT > 1) ? $clog2(PIX_PER_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PIX_PER_UNIT - 1);

  logic [H_W-1:0] hSyncSh, hBackSh, hActSh, hFrontSh;
  logic [V_W-1:0] vSyncSh, vBackSh, vActSh, vFrontSh;
  logic           hPolSh, vPolSh;
  logic [PRE_W-1:0] preCnt;
  logic loadNow;

  assign loadNow = !rstN || start;

  // Shadow copy of the timing inputs, captured only at reset or start
  always_ff @(posedge clk) begin
    if (loadNow) begin
      hSyncSh <= hSyncIn;  hBackSh <= hBackIn;
      hActSh  <= hActIn;   hFrontSh <= hFrontIn;
      vSyncSh <= vSyncIn;  vBackSh <= vBackIn;
      vActSh  <= vActIn;   vFrontSh <= vFrontIn;
      hPolSh  <= hPolIn;   vPolSh  <= vPolIn;
    end
  end

  // During the load cycle the datapath already sees the new values
  always_comb begin
    if (loadNow) begin
      hSyncCfg = hSyncIn;  hBackCfg = hBackIn;  hActCfg = hActIn;  hFrontCfg = hFrontIn;
      vSyncCfg = vSyncIn;  vBackCfg = vBackIn;  vActCfg = vActIn;  vFrontCfg = vFrontIn;
      hPolCfg  = hPolIn;   vPolCfg  = vPolIn;
    end else begin
      hSyncCfg = hSyncSh;  hBackCfg = hBackSh;  hActCfg = hActSh;  hFrontCfg = hFrontSh;
      vSyncCfg = vSyncSh;  vBackCfg = vBackSh;  vActCfg = vActSh;  vFrontCfg = vFrontSh;
      hPolCfg  = hPolSh;   vPolCfg  = vPolSh;
    end
  end

  // Pixel prescaler: one unit per PIX_PER_UNIT enabled cycles
  always_ff @(posedge clk) begin
    if (loadNow)    preCnt <= '0;
    else if (pixEn) preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
  end

  assign strb.restart  = loadNow;
  assign strb.unitTick = !loadNow && pixEn && (preCnt == PRE_LAST);

  // R2: a unit spans several enabled cycles, so ticks never come back to back
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.unitTick |=> !strb.unitTick);
endmodule

// File: rtl/vgaTimingDp.sv
module vgaTimingDp
  import vgaTimingPkg::*;
#(
  parameter int H_W = 8,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  vgaStrobe_t     strb,
  input  logic [H_W-1:0] hSyncCfg,
  input  logic [H_W-1:0] hBackCfg,
  input  logic [H_W-1:0] hActCfg,
  input  logic [H_W-1:0] hFrontCfg,
  input  logic [V_W-1:0] vSyncCfg,
  input  logic [V_W-1:0] vBackCfg,
  input  logic [V_W-1:0] vActCfg,
  input  logic [V_W-1:0] vFrontCfg,
  input  logic           hPolCfg,
  input  logic           vPolCfg,
  output logic           hSyncOut,
  output logic           vSyncOut,
  output logic           hActOut,
  output logic           vActOut,
  output logic           dispActive,
  output logic           frameDone
);
  localparam int HC_W = H_W + 2;
  localparam int VC_W = V_W + 2;

  logic [HC_W-1:0] hCnt, hActStart, hActEnd, hTotal;
  logic [VC_W-1:0] vCnt, vActStart, vActEnd, vTotal;
  logic lineLast, frameLast, hSyncOn, vSyncOn, hActOn, vActOn, lastActLine;

  assign hActStart = HC_W'(hSyncCfg) + HC_W'(hBackCfg);
  assign hActEnd   = hActStart + HC_W'(hActCfg);
  assign hTotal    = hActEnd + HC_W'(hFrontCfg);
  assign vActStart = VC_W'(vSyncCfg) + VC_W'(vBackCfg);
  assign vActEnd   = vActStart + VC_W'(vActCfg);
  assign vTotal    = vActEnd + VC_W'(vFrontCfg);

  assign lineLast    = (hCnt == hTotal - 1'b1);
  assign frameLast   = (vCnt == vTotal - 1'b1);
  assign lastActLine = (vCnt == vActEnd - 1'b1);
  assign hSyncOn     = (hCnt < HC_W'(hSyncCfg));
  assign vSyncOn     = (vCnt < VC_W'(vSyncCfg));
  assign hActOn      = (hCnt >= hActStart) && (hCnt < hActEnd);
  assign vActOn      = (vCnt >= vActStart) && (vCnt < vActEnd);

  // Raster position counters
  always_ff @(posedge clk) begin
    if (strb.restart) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.unitTick) begin
      if (lineLast) begin
        hCnt <= '0;
        vCnt <= frameLast ? '0 : vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  // Single aligned output stage
  always_ff @(posedge clk) begin
    if (strb.restart) begin
      hSyncOut   <= hPolCfg;
      vSyncOut   <= vPolCfg;
      hActOut    <= 1'b0;
      vActOut    <= 1'b0;
      dispActive <= 1'b0;
      frameDone  <= 1'b0;
    end else begin
      hSyncOut   <= hSyncOn ^ hPolCfg;
      vSyncOut   <= vSyncOn ^ vPolCfg;
      hActOut    <= hActOn;
      vActOut    <= vActOn;
      dispActive <= hActOn && vActOn;
      frameDone  <= strb.unitTick && lineLast && lastActLine;
    end
  end

  // R3: the horizontal position stays inside the programmed line
  assert_hpos_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.restart |-> (hCnt < hTotal));

  // R4: vertical sync only toggles where a new line begins
  assert_vsync_at_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(vSyncOut) && !$past(strb.restart)) |-> ($past(hCnt) == '0));

  // R6: the window never opens outside both axis flags
  assert_de_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    dispActive |-> (hActOut && vActOut));

  // R7: the frame event is a single-cycle pulse
  assert_frame_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
endmodule

// File: rtl/vgaTimingGen.sv
module vgaTimingGen
  import vgaTimingPkg::*;
#(
  parameter int H_W = 8,
  parameter int V_W = 10,
  parameter int PIX_PER_UNIT = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pixEn,
  input  logic           start,
  input  logic [H_W-1:0] hSyncLen,
  input  logic [H_W-1:0] hBackLen,
  input  logic [H_W-1:0] hActLen,
  input  logic [H_W-1:0] hFrontLen,
  input  logic [V_W-1:0] vSyncLen,
  input  logic [V_W-1:0] vBackLen,
  input  logic [V_W-1:0] vActLen,
  input  logic [V_W-1:0] vFrontLen,
  input  logic           hPolLow,
  input  logic           vPolLow,
  output logic           hSyncOut,
  output logic           vSyncOut,
  output logic           hActOut,
  output logic           vActOut,
  output logic           dispActive,
  output logic           frameDone
);
  vgaStrobe_t strb;
  logic [H_W-1:0] hSyncCfg, hBackCfg, hActCfg, hFrontCfg;
  logic [V_W-1:0] vSyncCfg, vBackCfg, vActCfg, vFrontCfg;
  logic hPolCfg, vPolCfg;

  vgaTimingCtrl #(.H_W(H_W), .V_W(V_W), .PIX_PER_UNIT(PIX_PER_UNIT)) uCtrl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .start(start),
    .hSyncIn(hSyncLen), .hBackIn(hBackLen), .hActIn(hActLen), .hFrontIn(hFrontLen),
    .vSyncIn(vSyncLen), .vBackIn(vBackLen), .vActIn(vActLen), .vFrontIn(vFrontLen),
    .hPolIn(hPolLow), .vPolIn(vPolLow),
    .hSyncCfg(hSyncCfg), .hBackCfg(hBackCfg), .hActCfg(hActCfg), .hFrontCfg(hFrontCfg),
    .vSyncCfg(vSyncCfg), .vBackCfg(vBackCfg), .vActCfg(vActCfg), .vFrontCfg(vFrontCfg),
    .hPolCfg(hPolCfg), .vPolCfg(vPolCfg), .strb(strb)
  );

  vgaTimingDp #(.H_W(H_W), .V_W(V_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hSyncCfg(hSyncCfg), .hBackCfg(hBackCfg), .hActCfg(hActCfg), .hFrontCfg(hFrontCfg),
    .vSyncCfg(vSyncCfg), .vBackCfg(vBackCfg), .vActCfg(vActCfg), .vFrontCfg(vFrontCfg),
    .hPolCfg(hPolCfg), .vPolCfg(vPolCfg),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .hActOut(hActOut), .vActOut(vActOut),
    .dispActive(dispActive), .frameDone(frameDone)
  );
endmodule

// File: tb/sim_vgaTimingGen.sv
module sim_vgaTimingGen;
  localparam int H_W = 8;
  localparam int V_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0, pixEn = 1'b1, start = 1'b0;
  logic [H_W-1:0] hS, hB, hA, hF;
  logic [V_W-1:0] vS, vB, vA, vF;
  logic hP, vP;
  logic hSyncOut, vSyncOut, hActOut, vActOut, dispActive, frameDone;

  int checks = 0, errors = 0;
  bit done = 0;
  int mhS, mhB, mhA, mhF, mvS, mvB, mvA, mvF, mhP, mvP;

  always #10 clk = ~clk;

  vgaTimingGen #(.H_W(H_W), .V_W(V_W), .PIX_PER_UNIT(8)) u0 (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .start(start),
    .hSyncLen(hS), .hBackLen(hB), .hActLen(hA), .hFrontLen(hF),
    .vSyncLen(vS), .vBackLen(vB), .vActLen(vA), .vFrontLen(vF),
    .hPolLow(hP), .vPolLow(vP),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .hActOut(hActOut), .vActOut(vActOut),
    .dispActive(dispActive), .frameDone(frameDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act[5:0], exp[5:0], $time);
    end
  endtask

  task automatic setIn(input int a, b, c, d, e, f, g, h, input int hp, vp);
    hS = H_W'(a); hB = H_W'(b); hA = H_W'(c); hF = H_W'(d);
    vS = V_W'(e); vB = V_W'(f); vA = V_W'(g); vF = V_W'(h);
    hP = hp[0]; vP = vp[0];
  endtask

  task automatic latchModel();
    mhS = int'(hS); mhB = int'(hB); mhA = int'(hA); mhF = int'(hF);
    mvS = int'(vS); mvB = int'(vB); mvA = int'(vA); mvF = int'(vF);
    mhP = int'(hP); mvP = int'(vP);
  endtask

  // Expected {hSync, vSync, hAct, vAct, dispActive, frameDone} for pixel index p (R2-R7)
  function automatic int expect6(input int p);
    int hT = mhS + mhB + mhA + mhF;
    int vT = mvS + mvB + mvA + mvF;
    int unit = p / 8;
    int hpos = unit % hT;
    int line = (unit / hT) % vT;
    int hs = ((hpos < mhS) ? 1 : 0) ^ mhP;
    int vs = ((line < mvS) ? 1 : 0) ^ mvP;
    int ha = (hpos >= mhS + mhB && hpos < mhS + mhB + mhA) ? 1 : 0;
    int va = (line >= mvS + mvB && line < mvS + mvB + mvA) ? 1 : 0;
    int fe = ((p % (8 * hT * vT)) == 8 * hT * (mvS + mvB + mvA) - 1) ? 1 : 0;
    return (hs << 5) | (vs << 4) | (ha << 3) | (va << 2) | ((ha & va) << 1) | fe;
  endfunction

  function automatic int outs6();
    return {26'd0, hSyncOut, vSyncOut, hActOut, vActOut, dispActive, frameDone};
  endfunction

  // Compare every output on every cycle from pixel index first onward
  task automatic checkSpan(input string req, input int first, input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      check(req, outs6(), expect6(first + i));
    end
  endtask

  task automatic doStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R10: the cycle after start shows inactive levels
    latchModel();
    check("R10 inactive after start", outs6(), (mhP << 5) | (mvP << 4));
  endtask

  // R1 and the main raster with active-high syncs
  task automatic testResetAndRaster();
    setIn(2, 1, 4, 1, 2, 1, 3, 2, 1, 1);
    repeat (3) @(negedge clk);
    check("R1 reset levels pol=1", outs6(), 6'b110000);
    setIn(2, 1, 4, 1, 2, 1, 3, 2, 0, 0);
    repeat (2) @(negedge clk);
    check("R1 reset levels pol=0", outs6(), 6'b000000);
    latchModel();
    rstN = 1'b1;
    // R2 R3 R4 R6 R7: two full frames of 512 cycles
    checkSpan("R3/R4/R6/R7 raster A", 0, 1024);
  endtask

  // R8: inputs changed without start are ignored
  task automatic testIgnore();
    setIn(1, 2, 3, 2, 1, 2, 2, 1, 1, 1);
    checkSpan("R8 inputs ignored", 1024, 700);
  endtask

  // R5 R10: start applies the staged mode with active-low syncs
  task automatic testStartPolarity();
    doStart();
    checkSpan("R5/R10 raster B low polarity", 0, 768);
  endtask

  // R9: gated pixel enable stretches all periods by two
  task automatic testStall();
    int cyc = 0, rise1 = -1, rise2 = -1, fall1 = -1;
    logic prevHs;
    setIn(2, 1, 4, 1, 2, 1, 3, 2, 0, 0);
    doStart();
    prevHs = hSyncOut;
    for (int i = 0; i < 400; i++) begin
      pixEn = ~pixEn;
      @(negedge clk);
      cyc++;
      if (hSyncOut && !prevHs) begin
        if (rise1 < 0) rise1 = cyc; else if (rise2 < 0) rise2 = cyc;
      end
      if (!hSyncOut && prevHs && rise1 >= 0 && fall1 < 0) fall1 = cyc;
      prevHs = hSyncOut;
    end
    pixEn = 1'b1;
    check("R9 line period with gated enable", rise2 - rise1, 128);
    check("R9 sync width with gated enable", fall1 - rise1, 32);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testResetAndRaster();
    testIgnore();
    testStartPolarity();
    testStall();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule